// File: doc/BRIEF.md
# Performance Event Counter Unit

The unit counts processor events for software that profiles code. It holds one fixed-function counter that counts retired instructions and two programmable counters. Each programmable counter has an event-select register that picks retired instructions, retired branches or unhalted cycles, and chooses which privilege levels are counted. A counter advances only when its own enable and its bit in a global control register are both set. Event inputs are single-cycle pulses, and `priv_user` gives the privilege level of the code that is running.

Software reaches every register through a register port with an address, write data, and separate read and write strobes. Every access gets a registered response one cycle later, with an error flag. A write that sets a bit the register does not implement is refused and the register keeps its old value. For sampling, software loads a counter with the negative of a trip count. When the counter wraps past its all-ones value it sets a sticky overflow status bit. The `irq` output stays high while an overflow is pending on a counter whose interrupt is enabled. Software clears the status and loads the counter again.

Address map (8-bit addresses): 0x10 + i is programmable counter i with a sign-extending write, 0x18 + i is the full-width alias of counter i, 0x20 + i is event select i, 0x30 is the fixed counter, 0x38 is fixed control, 0x40 is global control, 0x41 is overflow status (read only), and 0x42 is overflow clear (write only, reads as zero).

Top module: `pmu_unit`

## Requirements
- R1: The fixed counter adds one on each `ev_inst` pulse when global-control bit 32 is set and the fixed-control bit for the current privilege is set. Bit 0 counts kernel code (`priv_user`=0) and bit 1 counts user code (`priv_user`=1). Bit 3 of fixed control enables its overflow interrupt.
- R2: Only bits 0, 1, 2, 32, 33 and 34 of global control can be written. A write that sets any other bit returns an error and leaves the register unchanged. Accepted values read back exactly.
- R3: Programmable counter i adds one per cycle when all of the following hold: global-control bit i is set, select bit 22 is set, the privilege bit is set (select bit 16 for user, bit 17 for kernel), and the selected event pulses. Bits 15:0 of the select register choose the event: 0x00C0 is `ev_inst`, 0x8188 (unit mask 0x81 over code 0x88) is `ev_branch`, and 0x003C is `ev_cycle`. Any other code counts nothing.
- R4: Event select accepts only bits 15:0, 16, 17, 20 (interrupt enable) and 22. Fixed control accepts only bits 0, 1 and 3. A write that sets any other bit returns an error and leaves the register unchanged.
- R5: A write to a counter's normal address loads bits 31:0 from the write data and fills bits 47:32 with copies of data bit 31. Data bits 63:32 are ignored.
- R6: A write to the full-width alias of a programmable counter, or to the fixed counter's address, loads all 48 bits. Data bits 63:48 are ignored. If a counter is written and counts in the same cycle, the write wins.
- R7: A counter at 2^48-1 that counts wraps to zero and keeps counting from there without reloading. The wrap sets the counter's overflow status bit: bit 0 for counter 0, bit 1 for counter 1, bit 32 for the fixed counter.
- R8: Overflow status bits stay set until a write to the clear address with a 1 in the matching position. A write of 0 in that position leaves the bit set. Writing the status address returns an error.
- R9: `irq` is high while any status bit is set whose counter has its interrupt enabled, and low otherwise.
- R10: Every strobe gets `rsp_valid` in the next cycle. Unmapped addresses give `rsp_err` and zero read data. A read returns the register value as it stood before the update made in the cycle of the strobe.
- R11: After reset all registers and counters are zero, and `irq` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's strobe |
| rsp_err | output | 1 | Access was refused or unmapped |
| rsp_data | output | 64 | Read data |
| ev_inst | input | 1 | Instruction retired pulse |
| ev_branch | input | 1 | Branch retired pulse |
| ev_cycle | input | 1 | Unhalted cycle pulse |
| priv_user | input | 1 | 1 = user privilege, 0 = kernel |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest case to reach from the ports is a 48-bit counter wrapping, because counting from zero would take 2^48 events. The bench gets there the way sampling software does. It loads the negative of a short trip count, either as a 32-bit value through the sign-extending address or as a near-all-ones value through the full-width alias. It then counts events one at a time and checks that status and `irq` stay low until the last one. The gating of counting by privilege, event code and global enable is covered by sweeping every event combination under both privilege levels across sixteen control settings.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DW = 64;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_PMC_BASE  = 8'h10;
  localparam logic [AW-1:0] A_PMCW_BASE = 8'h18;
  localparam logic [AW-1:0] A_SEL_BASE  = 8'h20;
  localparam logic [AW-1:0] A_FIX       = 8'h30;
  localparam logic [AW-1:0] A_FCTL      = 8'h38;
  localparam logic [AW-1:0] A_GCTL      = 8'h40;
  localparam logic [AW-1:0] A_STAT      = 8'h41;
  localparam logic [AW-1:0] A_CLR       = 8'h42;

  localparam logic [DW-1:0] GCTL_MASK = 64'h0000_0007_0000_0007;
  localparam logic [DW-1:0] SEL_MASK  = 64'h0000_0000_0053_FFFF;
  localparam logic [DW-1:0] FCTL_MASK = 64'h0000_0000_0000_000B;

  localparam int GCTL_FIX_BIT = 32;
  localparam int FIX_OVF_BIT  = 32;

  localparam int SEL_USR = 16;
  localparam int SEL_KRN = 17;
  localparam int SEL_IE  = 20;
  localparam int SEL_EN  = 22;

  localparam int FCTL_KRN = 0;
  localparam int FCTL_USR = 1;
  localparam int FCTL_IE  = 3;

  localparam logic [15:0] EV_INST   = 16'h00C0;
  localparam logic [15:0] EV_BRANCH = 16'h8188;
  localparam logic [15:0] EV_CYCLE  = 16'h003C;
endpackage

// File: rtl/pmu_ctr.sv
module pmu_ctr #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld_lo,
  input  logic             ld_full,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam int LO_W = 32;
  localparam int HI_W = CNT_W - LO_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    wrap   = 1'b0;
    cnt_en = ld_full | ld_lo | inc;
    if (ld_full) begin
      cnt_d = wdata;
    end else if (ld_lo) begin
      cnt_d = {{HI_W{wdata[LO_W-1]}}, wdata[LO_W-1:0]};
    end else if (inc) begin
      {wrap, cnt_d} = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pmu_evsel.sv
module pmu_evsel
  import pmu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          gate,
  input  logic          priv_user,
  input  logic          ev_inst,
  input  logic          ev_branch,
  input  logic          ev_cycle,
  output logic [DW-1:0] sel,
  output logic          inc,
  output logic          ie
);
  logic [DW-1:0] sel_q;
  logic          ev_hit, priv_ok;

  always_comb begin
    unique case (sel_q[15:0])
      EV_INST:   ev_hit = ev_inst;
      EV_BRANCH: ev_hit = ev_branch;
      EV_CYCLE:  ev_hit = ev_cycle;
      default:   ev_hit = 1'b0;
    endcase
    priv_ok = priv_user ? sel_q[SEL_USR] : sel_q[SEL_KRN];
    inc     = gate & sel_q[SEL_EN] & priv_ok & ev_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (we) begin
      sel_q <= wdata;
    end
  end

  assign sel = sel_q;
  assign ie  = sel_q[SEL_IE];
endmodule

// File: rtl/pmu_regif.sv
module pmu_regif
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int NUM_PMC = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            acc_wr,
  input  logic                            acc_rd,
  input  logic [AW-1:0]                   acc_addr,
  input  logic [DW-1:0]                   acc_wdata,
  input  logic [NUM_PMC-1:0][CNT_W-1:0]   pmc_cnt,
  input  logic [NUM_PMC-1:0][DW-1:0]      sel_all,
  input  logic [CNT_W-1:0]                fix_cnt,
  input  logic [DW-1:0]                   fctl,
  input  logic [DW-1:0]                   gctl,
  input  logic [DW-1:0]                   ovf,
  output logic [NUM_PMC-1:0]              we_pmc_lo,
  output logic [NUM_PMC-1:0]              we_pmc_full,
  output logic [NUM_PMC-1:0]              we_sel,
  output logic                            we_fix,
  output logic                            we_fctl,
  output logic                            we_gctl,
  output logic                            we_clr,
  output logic                            rsp_valid,
  output logic                            rsp_err,
  output logic [DW-1:0]                   rsp_data
);
  logic          hit, bad;
  logic [DW-1:0] rd_val;
  logic          rsp_valid_d, rsp_err_d;
  logic [DW-1:0] rsp_data_d;
  logic          rsp_valid_q, rsp_err_q;
  logic [DW-1:0] rsp_data_q;

  always_comb begin
    hit         = 1'b0;
    bad         = 1'b0;
    rd_val      = '0;
    we_pmc_lo   = '0;
    we_pmc_full = '0;
    we_sel      = '0;
    we_fix      = 1'b0;
    we_fctl     = 1'b0;
    we_gctl     = 1'b0;
    we_clr      = 1'b0;
    for (int i = 0; i < NUM_PMC; i++) begin
      if (acc_addr == A_PMC_BASE + AW'(i)) begin
        hit          = 1'b1;
        rd_val       = DW'(pmc_cnt[i]);
        we_pmc_lo[i] = acc_wr;
      end
      if (acc_addr == A_PMCW_BASE + AW'(i)) begin
        hit            = 1'b1;
        rd_val         = DW'(pmc_cnt[i]);
        we_pmc_full[i] = acc_wr;
      end
      if (acc_addr == A_SEL_BASE + AW'(i)) begin
        hit    = 1'b1;
        rd_val = sel_all[i];
        if ((acc_wdata & ~SEL_MASK) != '0) bad = 1'b1;
        else                               we_sel[i] = acc_wr;
      end
    end
    if (acc_addr == A_FIX) begin
      hit    = 1'b1;
      rd_val = DW'(fix_cnt);
      we_fix = acc_wr;
    end
    if (acc_addr == A_FCTL) begin
      hit    = 1'b1;
      rd_val = fctl;
      if ((acc_wdata & ~FCTL_MASK) != '0) bad = 1'b1;
      else                                we_fctl = acc_wr;
    end
    if (acc_addr == A_GCTL) begin
      hit    = 1'b1;
      rd_val = gctl;
      if ((acc_wdata & ~GCTL_MASK) != '0) bad = 1'b1;
      else                                we_gctl = acc_wr;
    end
    if (acc_addr == A_STAT) begin
      hit    = 1'b1;
      rd_val = ovf;
      bad    = 1'b1;
    end
    if (acc_addr == A_CLR) begin
      hit    = 1'b1;
      we_clr = acc_wr;
    end

    rsp_valid_d = acc_wr | acc_rd;
    rsp_err_d   = acc_wr ? (~hit | bad) : (acc_rd & ~hit);
    rsp_data_d  = (acc_rd & ~acc_wr) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int NUM_PMC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [7:0]    acc_addr,
  input  logic [63:0]   acc_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [63:0]   rsp_data,
  input  logic          ev_inst,
  input  logic          ev_branch,
  input  logic          ev_cycle,
  input  logic          priv_user,
  output logic          irq
);
  logic [NUM_PMC-1:0][CNT_W-1:0] pmc_cnt;
  logic [NUM_PMC-1:0][DW-1:0]    sel_all;
  logic [NUM_PMC-1:0]            we_pmc_lo, we_pmc_full, we_sel;
  logic [NUM_PMC-1:0]            pmc_inc, pmc_wrap, pmc_ie;
  logic                          we_fix, we_fctl, we_gctl, we_clr;
  logic [CNT_W-1:0]              fix_cnt;
  logic                          fix_inc, fix_wrap;
  logic [DW-1:0]                 gctl_q, fctl_q, ovf_q, ovf_d;
  logic [DW-1:0]                 set_v, ie_v;
  logic                          ovf_en;

  pmu_regif #(.CNT_W(CNT_W), .NUM_PMC(NUM_PMC)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .pmc_cnt    (pmc_cnt),
    .sel_all    (sel_all),
    .fix_cnt    (fix_cnt),
    .fctl       (fctl_q),
    .gctl       (gctl_q),
    .ovf        (ovf_q),
    .we_pmc_lo  (we_pmc_lo),
    .we_pmc_full(we_pmc_full),
    .we_sel     (we_sel),
    .we_fix     (we_fix),
    .we_fctl    (we_fctl),
    .we_gctl    (we_gctl),
    .we_clr     (we_clr),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_data   (rsp_data)
  );

  for (genvar g = 0; g < NUM_PMC; g++) begin : g_pmc
    pmu_evsel u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we_sel[g]),
      .wdata    (acc_wdata),
      .gate     (gctl_q[g]),
      .priv_user(priv_user),
      .ev_inst  (ev_inst),
      .ev_branch(ev_branch),
      .ev_cycle (ev_cycle),
      .sel      (sel_all[g]),
      .inc      (pmc_inc[g]),
      .ie       (pmc_ie[g])
    );
    pmu_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (pmc_inc[g]),
      .ld_lo  (we_pmc_lo[g]),
      .ld_full(we_pmc_full[g]),
      .wdata  (acc_wdata[CNT_W-1:0]),
      .cnt    (pmc_cnt[g]),
      .wrap   (pmc_wrap[g])
    );
  end

  assign fix_inc = ev_inst & gctl_q[GCTL_FIX_BIT] &
                   (priv_user ? fctl_q[FCTL_USR] : fctl_q[FCTL_KRN]);

  pmu_ctr #(.CNT_W(CNT_W)) u_fix (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (fix_inc),
    .ld_lo  (1'b0),
    .ld_full(we_fix),
    .wdata  (acc_wdata[CNT_W-1:0]),
    .cnt    (fix_cnt),
    .wrap   (fix_wrap)
  );

  always_comb begin
    set_v = '0;
    ie_v  = '0;
    for (int i = 0; i < NUM_PMC; i++) begin
      set_v[i] = pmc_wrap[i];
      ie_v[i]  = pmc_ie[i];
    end
    set_v[FIX_OVF_BIT] = fix_wrap;
    ie_v[FIX_OVF_BIT]  = fctl_q[FCTL_IE];
    ovf_d  = (ovf_q & ~(we_clr ? acc_wdata : '0)) | set_v;
    ovf_en = we_clr | (set_v != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q <= '0;
      fctl_q <= '0;
      ovf_q  <= '0;
    end else begin
      if (we_gctl) gctl_q <= acc_wdata;
      if (we_fctl) fctl_q <= acc_wdata;
      if (ovf_en)  ovf_q  <= ovf_d;
    end
  end

  assign irq = |(ovf_q & ie_v);
endmodule

// File: rtl/pmu_unit_chk.sv
module pmu_unit_chk
  import pmu_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_wr,
  input logic             acc_rd,
  input logic [AW-1:0]    acc_addr,
  input logic [DW-1:0]    acc_wdata,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             irq,
  input logic [DW-1:0]    gctl,
  input logic [DW-1:0]    sel0,
  input logic [DW-1:0]    ovf,
  input logic [CNT_W-1:0] fix_cnt,
  input logic [CNT_W-1:0] pmc0_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_GCTL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_addr == A_GCTL && (acc_wdata & ~GCTL_MASK) != '0) |=> ($stable(gctl) && rsp_err)); // R2

  AST_SEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_addr == A_SEL_BASE && (acc_wdata & ~SEL_MASK) != '0) |=> ($stable(sel0) && rsp_err)); // R4

  AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!gctl[GCTL_FIX_BIT] && !(acc_wr && acc_addr == A_FIX)) |=> $stable(fix_cnt)); // R1

  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(acc_wr) && $past(pmc0_cnt) == CMAX && pmc0_cnt == '0) |-> ovf[0]); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !(acc_wr && acc_addr == A_CLR)) |=> ovf[0]); // R8

  AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf != '0)); // R9

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr || acc_rd) |=> rsp_valid); // R10

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr || acc_rd) |=> !rsp_valid); // R10
endmodule

bind pmu_unit pmu_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_wr   (acc_wr),
  .acc_rd   (acc_rd),
  .acc_addr (acc_addr),
  .acc_wdata(acc_wdata),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .irq      (irq),
  .gctl     (gctl_q),
  .sel0     (sel_all[0]),
  .ovf      (ovf_q),
  .fix_cnt  (fix_cnt),
  .pmc0_cnt (pmc_cnt[0])
);

// File: tb/pmu_unit_tb_top.sv
`timescale 1ns/1ps
module pmu_unit_tb_top;
  import pmu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_data;
  logic        ev_inst = 1'b0, ev_branch = 1'b0, ev_cycle = 1'b0, priv_user = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [63:0] gm, fm;
  logic [63:0] sm [2];
  logic [63:0] exp_pmc [2];
  logic [63:0] exp_fix;

  always #2 clk = ~clk;

  pmu_unit dut_i (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .ev_inst(ev_inst),
    .ev_branch(ev_branch), .ev_cycle(ev_cycle), .priv_user(priv_user), .irq(irq)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [63:0] d, input logic exp_err, input string req);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
    check(req, "write error flag", {63'd0, rsp_err}, {63'd0, exp_err});
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [63:0] exp, input string req);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_rd = 1'b0;
    check(req, "read data", rsp_data, exp);
  endtask

  function automatic logic ev_sel_hit(input logic [63:0] s, input logic [2:0] e);
    case (s[15:0])
      16'h00C0: return e[0];
      16'h8188: return e[1];
      16'h003C: return e[2];
      default:  return 1'b0;
    endcase
  endfunction

  // one cycle of event pulses; expected counts follow R1 and R3
  task automatic pulse(input logic [2:0] e, input logic p);
    @(negedge clk);
    ev_inst = e[0]; ev_branch = e[1]; ev_cycle = e[2]; priv_user = p;
    if (gm[32] && e[0] && (p ? fm[1] : fm[0])) exp_fix = exp_fix + 1;
    for (int i = 0; i < 2; i++)
      if (gm[i] && sm[i][22] && (p ? sm[i][16] : sm[i][17]) && ev_sel_hit(sm[i], e))
        exp_pmc[i] = exp_pmc[i] + 1;
    @(negedge clk);
    ev_inst = 1'b0; ev_branch = 1'b0; ev_cycle = 1'b0;
  endtask

  function automatic logic [63:0] sel0_pick(input int k);
    case (k)
      0: return 64'h0043_00C0;
      1: return 64'h0043_8188;
      2: return 64'h0041_003C;
      default: return 64'h0042_0055;
    endcase
  endfunction

  function automatic logic [63:0] sel1_pick(input int k);
    case (k)
      0: return 64'h0042_8188;
      1: return 64'h0042_00C0;
      2: return 64'h0043_003C;
      default: return 64'h0003_8188;
    endcase
  endfunction

  function automatic logic [63:0] gctl_pick(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'h1_0000_0003;
      2: return 64'h1_0000_0001;
      default: return 64'h0_0000_0002;
    endcase
  endfunction

  initial begin
    exp_fix = '0; exp_pmc[0] = '0; exp_pmc[1] = '0;
    gm = '0; fm = '0; sm[0] = '0; sm[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11", "irq after reset", {63'd0, irq}, 64'd0);
    check("R11", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    do_rd(A_PMC_BASE, 64'd0, "R11");
    do_rd(A_PMC_BASE + 8'd1, 64'd0, "R11");
    do_rd(A_FIX, 64'd0, "R11");
    do_rd(A_GCTL, 64'd0, "R11");
    do_rd(A_STAT, 64'd0, "R11");

    // R10 access responses
    do_rd(8'h7F, 64'd0, "R10");
    check("R10", "unmapped read error", {63'd0, rsp_err}, 64'd1);
    do_rd(A_CLR, 64'd0, "R10");
    check("R10", "clear read error", {63'd0, rsp_err}, 64'd0);
    do_wr(8'h7F, 64'h1, 1'b1, "R10");
    do_wr(A_STAT, 64'h1, 1'b1, "R8");

    // R2 single-bit sweep of global control
    for (int b = 0; b < 64; b++) begin
      logic ok;
      ok = GCTL_MASK[b];
      do_wr(A_GCTL, 64'd1 << b, !ok, "R2");
      if (ok) gm = 64'd1 << b;
      do_rd(A_GCTL, gm, "R2");
    end
    do_wr(A_GCTL, 64'h0000_0007_0000_0007, 1'b0, "R2");
    do_rd(A_GCTL, 64'h0000_0007_0000_0007, "R2");
    do_wr(A_GCTL, 64'h0000_0007_8000_0000, 1'b1, "R2");
    do_rd(A_GCTL, 64'h0000_0007_0000_0007, "R2");
    gm = 64'h0000_0007_0000_0007;

    // R4 sweeps of event select 0 and fixed control
    for (int b = 0; b < 40; b++) begin
      logic ok;
      ok = SEL_MASK[b];
      do_wr(A_SEL_BASE, 64'd1 << b, !ok, "R4");
      if (ok) sm[0] = 64'd1 << b;
      do_rd(A_SEL_BASE, sm[0], "R4");
    end
    for (int b = 0; b < 8; b++) begin
      logic ok;
      ok = FCTL_MASK[b];
      do_wr(A_FCTL, 64'd1 << b, !ok, "R4");
      if (ok) fm = 64'd1 << b;
      do_rd(A_FCTL, fm, "R4");
    end

    // R1 / R3 sweep: control settings x privilege x event combinations
    gm = '0; do_wr(A_GCTL, gm, 1'b0, "R3");
    do_wr(A_PMCW_BASE, 64'd0, 1'b0, "R6");
    do_wr(A_PMCW_BASE + 8'd1, 64'd0, 1'b0, "R6");
    do_wr(A_FIX, 64'd0, 1'b0, "R6");
    exp_pmc[0] = '0; exp_pmc[1] = '0; exp_fix = '0;
    for (int k = 0; k < 16; k++) begin
      sm[0] = sel0_pick(k % 4); do_wr(A_SEL_BASE, sm[0], 1'b0, "R3");
      sm[1] = sel1_pick((k / 4 + k) % 4); do_wr(A_SEL_BASE + 8'd1, sm[1], 1'b0, "R3");
      fm = 64'(k % 4); do_wr(A_FCTL, fm, 1'b0, "R1");
      gm = gctl_pick(k / 4); do_wr(A_GCTL, gm, 1'b0, "R3");
      for (int p = 0; p < 2; p++)
        for (int e = 0; e < 8; e++)
          pulse(3'(e), 1'(p));
      do_rd(A_FIX, exp_fix, "R1");
      do_rd(A_PMC_BASE, exp_pmc[0], "R3");
      do_rd(A_PMC_BASE + 8'd1, exp_pmc[1], "R3");
    end

    // R5 sign-extending write, R6 full-width alias
    gm = '0; do_wr(A_GCTL, gm, 1'b0, "R5");
    do_wr(A_PMC_BASE, 64'hABCD_0000_8000_0001, 1'b0, "R5");
    do_rd(A_PMC_BASE, 64'h0000_FFFF_8000_0001, "R5");
    do_wr(A_PMC_BASE + 8'd1, 64'hFFFF_FFFF_7FFF_FFFF, 1'b0, "R5");
    do_rd(A_PMC_BASE + 8'd1, 64'h0000_0000_7FFF_FFFF, "R5");
    do_wr(A_PMCW_BASE, 64'hFFFF_1234_5678_9ABC, 1'b0, "R6");
    do_rd(A_PMC_BASE, 64'h0000_1234_5678_9ABC, "R6");
    do_wr(A_FIX, 64'hEEEE_8765_4321_0FED, 1'b0, "R6");
    do_rd(A_FIX, 64'h0000_8765_4321_0FED, "R6");

    // R7 / R9 preload -4 on counter 0, user instructions, interrupt on
    sm[0] = 64'h0051_00C0; do_wr(A_SEL_BASE, sm[0], 1'b0, "R7");
    sm[1] = 64'h0042_8188; do_wr(A_SEL_BASE + 8'd1, sm[1], 1'b0, "R7");
    do_wr(A_PMC_BASE, 64'h0000_0000_FFFF_FFFC, 1'b0, "R7");
    do_rd(A_PMC_BASE, 64'h0000_FFFF_FFFF_FFFC, "R5");
    gm = 64'h1; do_wr(A_GCTL, gm, 1'b0, "R7");
    for (int n = 0; n < 3; n++) pulse(3'b001, 1'b1);
    check("R9", "irq before wrap", {63'd0, irq}, 64'd0);
    do_rd(A_STAT, 64'd0, "R7");
    pulse(3'b001, 1'b1);
    check("R9", "irq after wrap", {63'd0, irq}, 64'd1);
    do_rd(A_STAT, 64'h1, "R7");
    do_rd(A_PMC_BASE, 64'd0, "R7");
    pulse(3'b001, 1'b1);
    do_rd(A_PMC_BASE, 64'd1, "R7");
    check("R9", "irq held", {63'd0, irq}, 64'd1);
    do_wr(A_CLR, 64'h2, 1'b0, "R8");
    do_rd(A_STAT, 64'h1, "R8");
    do_wr(A_CLR, 64'h1, 1'b0, "R8");
    do_rd(A_STAT, 64'h0, "R8");
    check("R9", "irq after clear", {63'd0, irq}, 64'd0);

    // R7 / R9 counter 1 wraps with interrupt disabled
    gm = 64'h2; do_wr(A_GCTL, gm, 1'b0, "R7");
    do_wr(A_PMCW_BASE + 8'd1, 64'h0000_FFFF_FFFF_FFFE, 1'b0, "R6");
    pulse(3'b010, 1'b0);
    pulse(3'b010, 1'b0);
    do_rd(A_STAT, 64'h2, "R7");
    check("R9", "irq with interrupt off", {63'd0, irq}, 64'd0);

    // R7 / R9 fixed counter wraps with fixed-control bit 3
    fm = 64'hB; do_wr(A_FCTL, fm, 1'b0, "R1");
    gm = 64'h1_0000_0000; do_wr(A_GCTL, gm, 1'b0, "R1");
    do_wr(A_FIX, 64'h0000_FFFF_FFFF_FFFF, 1'b0, "R6");
    pulse(3'b001, 1'b1);
    do_rd(A_STAT, 64'h1_0000_0002, "R7");
    do_rd(A_FIX, 64'd0, "R7");
    check("R9", "irq fixed wrap", {63'd0, irq}, 64'd1);
    do_wr(A_CLR, 64'h1_0000_0002, 1'b0, "R8");
    check("R9", "irq fixed cleared", {63'd0, irq}, 64'd0);
    do_rd(A_STAT, 64'd0, "R8");

    summary();
  end
endmodule